// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM that has active-low chip-select, write-enable and output-enable pins. The host issues one access at a time through a request/ready handshake: it presents a 15-bit address, a write flag and 8 bits of write data. A read returns 8 bits of data together with a valid strobe that is high for one cycle.

On the memory side the controller drives the address, the three strobes and a split data bus made of an output value, an input value and a driver enable. Every strobe phase lasts a whole number of clock cycles. Each count is the nanosecond timing limit of the memory divided by the clock-period parameter, rounded up, and never less than one. With the defaults (10 ns clock, 55 ns memory grade) the counts are:

- a write: one setup cycle, a 4-cycle write-enable pulse, and one recovery cycle;
- a read: a 6-cycle read window, with the data sampled at the end of it;
- after a read: a 2-cycle bus-release gap before the next access.

The release gap means the controller and the memory never drive the data bus at the same time.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip-select, write-enable and output-enable are high (1), the data driver enable is 0, ready is 1 and read-valid is 0.
- R2: A request is taken on a clock edge where req and ready are both 1. Ready is 0 from the cycle after acceptance until the access has fully finished. A request raised while ready is 0 is ignored: it changes neither the address being used nor memory contents.
- R3: A write (wr=1) starts with one setup cycle. In that cycle chip-select is low, write-enable is high, output-enable is high, the address is on the bus and the write data is driven with the driver enable at 1.
- R4: After the setup cycle, write-enable is low for exactly 4 cycles by default. Then follows one recovery cycle with chip-select and write-enable high and the driver enable at 0. Ready returns in the 7th cycle after the accepting edge.
- R5: A read (wr=0) holds chip-select and output-enable low and write-enable high for exactly 6 cycles by default, with the address stable. The memory data is sampled at the end of the 6th cycle. That value appears on rdata with rvalid=1 for exactly one cycle, in the cycle after the sample.
- R6: After a read, chip-select and output-enable are high and the driver is off for 2 cycles by default. Ready returns in the 9th cycle after the accepting edge.
- R7: The data driver enable is never 1 while output-enable is low. Write-enable falls only after a cycle in which write data was already driven.
- R8: Write-enable and output-enable are never low together.
- R9: While chip-select is high, write-enable and output-enable are both high.
- R10: While chip-select stays low, the memory address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request |
| ready | output | 1 | Controller idle, request can be taken |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-cycle strobe for rdata |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Enable for the data driver toward memory |

## Verification
All timing is counted from the clock edge that accepts the request:

| Access | Event | When |
|---|---|---|
| Write | setup cycle | cycle 1 |
| Write | write-enable low | cycles 2 to 5 |
| Write | recovery | cycle 6 |
| Write | ready returns | cycle 7 |
| Read | read window | cycles 1 to 6 |
| Read | rvalid high | cycle 7 |
| Read | bus-release gap | cycles 7 and 8 |
| Read | ready returns | cycle 9 |

The bench drives inputs and samples outputs on falling edges and steps through an access one falling edge at a time, so every check falls inside the cycle it names. Its memory model drives valid read data only from the 6th read cycle onward, so sampling even one cycle early returns a wrong value.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WC_NS = 55,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45,
  parameter int T_WP_NS = 40,
  parameter int T_DW_NS = 25,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_CO_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  output logic          ready,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_WP   = mx(mx(cyc(T_WP_NS), cyc(T_AW_NS) - 1),
                             mx(cyc(T_DW_NS) - 1, cyc(T_CW_NS) - 1));
  localparam int C_WREC = mx(1, cyc(T_WC_NS) - C_WP - 1);
  localparam int C_RD   = mx(mx(cyc(T_RC_NS), cyc(T_AA_NS)),
                             mx(cyc(T_CO_NS), cyc(T_OE_NS)));
  localparam int C_TURN = cyc(T_HZ_NS);
  localparam int C_MAX  = mx(mx(C_WP, C_WREC), mx(C_RD, C_TURN));
  localparam int CW     = $clog2(C_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WREC, S_READ, S_TURN
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          last;

  assign ready = (state == S_IDLE);
  assign last  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_cs_n <= 1'b0;
          if (wr) begin
            mem_dq_out <= wdata;
            mem_dq_oe  <= 1'b1;
            state      <= S_WSET;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(C_RD - 1);
            state    <= S_READ;
          end
        end
        S_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= CW'(C_WP - 1);
          state    <= S_WPUL;
        end
        S_WPUL: if (last) begin
          mem_we_n  <= 1'b1;
          mem_cs_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          cnt       <= CW'(C_WREC - 1);
          state     <= S_WREC;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_READ: if (last) begin
          rdata    <= mem_dq_in;
          rvalid   <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          cnt      <= CW'(C_TURN - 1);
          state    <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          ready,
  input logic          rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);

  a_r9_cs_gates: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_we_n && mem_oe_n));

  a_r8_we_oe_apart: assert property (@(posedge clk) disable iff (rst)
    mem_we_n || mem_oe_n);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r7_data_first: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req && ready) |=> !ready);

  a_r2_busy_active: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !ready);

  a_r6_release_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (!mem_dq_oe && !ready));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .ready(ready), .rvalid(rvalid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  int clash  = 0;
  int overlap = 0;

  always #10 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  logic [7:0] model [logic [14:0]];
  logic [7:0] rd_val = 8'h00;
  int         rd_age = 0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) model[mem_addr] = mem_dq_out;
    rd_val = model.exists(mem_addr) ? model[mem_addr] : 8'h00;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age = rd_age + 1;
    else rd_age = 0;
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= 5)
                     ? rd_val : 8'hEE;

  always @(negedge clk) begin
    if (!rst && mem_dq_oe && !mem_oe_n) clash++;
    if (!rst && !mem_we_n && !mem_oe_n) overlap++;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes in reset",
        {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && ready && !rvalid, "R1 driver/ready/valid in reset",
        {mem_dq_oe, ready, rvalid}, 3'b010);
    rst = 1'b0;
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready} == 5'b11101,
        "R1 after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d,
                         input bit intrude);
    @(negedge clk);
    chk(ready, "R2 ready before write", ready, 1);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b0111, "R3 setup strobes",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
    chk(mem_addr == a && mem_dq_out == d, "R3 setup addr/data",
        {mem_addr, mem_dq_out}, {a, d});
    chk(!ready, "R2 busy after accept", ready, 0);
    if (intrude) begin
      req = 1'b1; wr = 1'b1; addr = a ^ 15'h0300; wdata = 8'h99;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b0011, "R4 write pulse",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
      if (intrude)
        chk(mem_addr == a && mem_dq_out == d, "R2 request ignored while busy",
            {mem_addr, mem_dq_out}, {a, d});
    end
    @(negedge clk);
    req = 1'b0;
    chk({mem_cs_n, mem_we_n, mem_dq_oe, ready} == 4'b1100, "R4 recovery cycle",
        {mem_cs_n, mem_we_n, mem_dq_oe, ready}, 4'b1100);
    @(negedge clk);
    chk(ready, "R4 ready in 7th cycle", ready, 1);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
    @(negedge clk);
    chk(ready, "R2 ready before read", ready, 1);
    req = 1'b1; wr = 1'b0; addr = a;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req = 1'b0;
      chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, rvalid} == 6'b001000,
          "R5 read window", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, rvalid},
          6'b001000);
      chk(mem_addr == a, "R5 read address", mem_addr, a);
    end
    @(negedge clk);
    chk(rvalid && rdata == exp, "R5 read data", {rvalid, rdata}, {1'b1, exp});
    chk({mem_cs_n, mem_oe_n, mem_dq_oe} == 3'b110, "R6 bus released",
        {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b110);
    @(negedge clk);
    chk(!rvalid, "R5 valid one cycle", rvalid, 0);
    chk(!ready && !mem_dq_oe, "R6 gap second cycle", {ready, mem_dq_oe}, 2'b00);
    @(negedge clk);
    chk(ready, "R6 ready in 9th cycle", ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write(15'h1234, 8'hA5, 1'b0);
    t_read(15'h1234, 8'hA5);
    t_write(15'h7FFF, 8'h3C, 1'b0);
    t_write(15'h0000, 8'hC3, 1'b0);
    t_read(15'h7FFF, 8'h3C);
    t_read(15'h0000, 8'hC3);
    t_write(15'h0100, 8'h11, 1'b1);
    t_read(15'h0200, 8'h00);
    t_read(15'h0100, 8'h11);
    t_write(15'h1234, 8'h5A, 1'b0);
    t_read(15'h1234, 8'h5A);
    chk(clash == 0, "R7 no bus contention", clash, 0);
    chk(overlap == 0, "R8 we/oe never both low", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule